// File: doc/BRIEF.md
# Serial Configuration Stream Parser

This block takes a configuration bitstream one bit per accepted clock and splits it into its parts. It first hunts for a run of eight one bits and a fixed preamble code. In serial mode it then captures a 24-bit length count, skips a short separator of ones, and walks through a fixed number of fixed-length data frames. Each frame begins with a one-bit start field and, in serial mode, ends with a 4-bit CRC check. After the frames it checks a postamble code and compares the total number of bits against the captured length. Finally it counts four start-up clocks and raises a sticky done flag.

In byte-wide mode the same parser is fed from a small serializer. Each loaded byte is replayed bit by bit, lowest data bit first. In this mode a 24-bit fill field replaces the length count and separator, frames carry no CRC, and there is no postamble or length check. After the last frame the parser goes straight to the start-up count. Each recovered frame word leaves the block with a one-cycle valid strobe and an error flag.

Top module: `cfgStreamParser`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to its idle state. Afterwards `done`, `locked`, `wordValid`, `frameErr` and `endErr` are low, `lengthOut` is zero, and the parser waits for leading ones.
- R2: In serial mode a bit is taken from `dataIn[0]` only at an edge where `inValid` is high, and `dataIn[7:1]` is ignored. The header must be eight ones followed by the preamble 0010, sent most significant bit first. A zero among the ones, or any preamble bit that does not match, restarts the search for eight ones.
- R3: In serial mode the 24 bits after the preamble form the length count, most significant bit first, and are shown on `lengthOut`. The four separator bits that follow are skipped. `lengthOut` does not change while `locked` is high.
- R4: A frame is one start bit followed by FRAME_BITS data bits. The first data bit received becomes the MSB of `wordOut`. `wordValid` is high for exactly one cycle, in the cycle after the frame's last bit (the last CRC bit in serial mode, the last data bit in byte-wide mode).
- R5: In serial mode, 4 check bits (MSB first) follow the data. They are compared with a CRC register that starts at zero for each frame and is updated once per data bit as follows: feedback = crc[3] XOR bit, crc = (crc shifted left by one) XOR (feedback ? 0011 : 0000). `frameErr` is high together with `wordValid` when the check bits differ from the CRC or when the start bit was 1.
- R6: In serial mode, after NUM_FRAMES frames, a 4-bit postamble 0111 (MSB first) is expected. The total number of accepted bits is counted from the first of the eight leading ones up to the last postamble bit. `endErr` is set if the postamble differs or if this total differs from the length count. Once set, `endErr` stays high until reset.
- R7: After the data, four more accepted bits of any value serve as start-up clocks. `done` rises in the cycle after the fourth of them and stays high until reset. After that, input produces no words and changes no output.
- R8: When `byteMode` is high, each `inValid` edge loads `dataIn`, and the block then replays its bits over the next 8 cycles, `dataIn[0]` first. The header is eight ones, the preamble 0010 and then 24 ignored fill bits. Frames carry no CRC, so `frameErr` reflects only the start bit. `lengthOut` stays zero and `endErr` stays low. The start-up count follows directly after the last frame.
- R9: `locked` rises when the first frame's start field is reached and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset, active high |
| byteMode | input | 1 | 1 selects byte-wide input; hold steady between resets |
| inValid | input | 1 | Bit strobe in serial mode, byte load strobe in byte mode |
| dataIn | input | 8 | Serial bit on bit 0, or a whole byte |
| wordOut | output | FRAME_BITS | Data word of the latest frame |
| wordValid | output | 1 | One-cycle strobe for `wordOut` |
| frameErr | output | 1 | Start or CRC error, qualified by `wordValid` |
| lengthOut | output | 24 | Captured length count |
| endErr | output | 1 | Sticky postamble or length mismatch |
| locked | output | 1 | Header accepted, frame phase reached |
| done | output | 1 | Start-up count complete, sticky |

## Verification
Some properties are checked on every cycle: the reset state, the stickiness of `done`, `endErr` and `locked`, the single-cycle width of `wordValid`, `frameErr` only appearing with a word, `lengthOut` holding once locked, and zero length with no end error in byte-wide mode. Other behaviour can only be shown by the bench scenarios. These are the header restart after noise, the word contents and CRC verdicts, a wrong length count or postamble, the exact cycle in which `done` rises, and the byte-wide replay order.

// File: rtl/cfgStreamPkg.sv
package cfgStreamPkg;

  typedef enum logic [3:0] {
    ST_SEEK, ST_PRE, ST_LEN, ST_SEP, ST_FILL,
    ST_START, ST_DATA, ST_CHECK, ST_POST, ST_WAKE, ST_DONE
  } parseState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic clrBits;
    logic incBits;
    logic shLen;
    logic frameStart;
    logic shData;
    logic shChk;
    logic emit;
    logic shPost;
    logic endCheck;
  } strobe_t;

endpackage

// File: rtl/cfgParseCtrl.sv
module cfgParseCtrl
  import cfgStreamPkg::*;
#(
  parameter int FRAME_BITS   = 8,
  parameter int NUM_FRAMES   = 3,
  parameter int LEN_BITS     = 24,
  parameter int SEP_BITS     = 4,
  parameter int FILL_BITS    = 24,
  parameter int CRC_BITS     = 4,
  parameter int LEAD_ONES    = 8,
  parameter int PRE_BITS     = 4,
  parameter logic [PRE_BITS-1:0] PREAMBLE = 4'b0010,
  parameter int POST_BITS    = 4,
  parameter int STARTUP_CLKS = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    byteMode,
  input  logic    bitValid,
  input  logic    bitIn,
  output strobe_t stb,
  output logic    locked,
  output logic    done
);

  localparam int CNT_W = $clog2(LEN_BITS + FILL_BITS + FRAME_BITS + SEP_BITS + CRC_BITS
                                + PRE_BITS + POST_BITS + LEAD_ONES + STARTUP_CLKS + 1);
  localparam int FRM_W = $clog2(NUM_FRAMES + 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST_ONES = CNT_W'(LEAD_ONES - 1);
  localparam logic [CNT_W-1:0] LAST_PRE  = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_LEN  = CNT_W'(LEN_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_SEP  = CNT_W'(SEP_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_FILL = CNT_W'(FILL_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_CHK  = CNT_W'(CRC_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_POST = CNT_W'(POST_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_WAKE = CNT_W'(STARTUP_CLKS - 1);
  localparam logic [FRM_W-1:0] LAST_FRM  = FRM_W'(NUM_FRAMES - 1);

  parseState_t state, nextState;
  logic [CNT_W-1:0] fieldCnt, nextCnt;
  logic [FRM_W-1:0] frameCnt, nextFrm;
  logic [PRE_BITS-1:0] preShift;
  logic lastFrame;

  assign preShift  = PREAMBLE << fieldCnt;
  assign lastFrame = (frameCnt == LAST_FRM);

  always_comb begin
    stb       = '0;
    nextState = state;
    nextCnt   = fieldCnt;
    nextFrm   = frameCnt;
    if (bitValid) begin
      unique case (state)
        ST_SEEK: begin
          if (bitIn) begin
            stb.incBits = 1'b1;
            if (fieldCnt == LAST_ONES) begin nextState = ST_PRE; nextCnt = '0; end
            else nextCnt = fieldCnt + ONE;
          end else begin
            stb.clrBits = 1'b1;
            nextCnt     = '0;
          end
        end
        ST_PRE: begin
          if (bitIn != preShift[PRE_BITS-1]) begin
            stb.clrBits = 1'b1;
            nextState   = ST_SEEK;
            nextCnt     = '0;
          end else begin
            stb.incBits = 1'b1;
            if (fieldCnt == LAST_PRE) begin
              nextState = byteMode ? ST_FILL : ST_LEN;
              nextCnt   = '0;
            end else nextCnt = fieldCnt + ONE;
          end
        end
        ST_LEN: begin
          stb.incBits = 1'b1;
          stb.shLen   = 1'b1;
          if (fieldCnt == LAST_LEN) begin nextState = ST_SEP; nextCnt = '0; end
          else nextCnt = fieldCnt + ONE;
        end
        ST_SEP: begin
          stb.incBits = 1'b1;
          if (fieldCnt == LAST_SEP) begin nextState = ST_START; nextCnt = '0; end
          else nextCnt = fieldCnt + ONE;
        end
        ST_FILL: begin
          stb.incBits = 1'b1;
          if (fieldCnt == LAST_FILL) begin nextState = ST_START; nextCnt = '0; end
          else nextCnt = fieldCnt + ONE;
        end
        ST_START: begin
          stb.incBits    = 1'b1;
          stb.frameStart = 1'b1;
          nextState      = ST_DATA;
          nextCnt        = '0;
        end
        ST_DATA: begin
          stb.incBits = 1'b1;
          stb.shData  = 1'b1;
          if (fieldCnt == LAST_DATA) begin
            nextCnt = '0;
            if (byteMode) begin
              stb.emit  = 1'b1;
              nextFrm   = frameCnt + FRM_W'(1);
              nextState = lastFrame ? ST_WAKE : ST_START;
            end else nextState = ST_CHECK;
          end else nextCnt = fieldCnt + ONE;
        end
        ST_CHECK: begin
          stb.incBits = 1'b1;
          stb.shChk   = 1'b1;
          if (fieldCnt == LAST_CHK) begin
            stb.emit  = 1'b1;
            nextCnt   = '0;
            nextFrm   = frameCnt + FRM_W'(1);
            nextState = lastFrame ? ST_POST : ST_START;
          end else nextCnt = fieldCnt + ONE;
        end
        ST_POST: begin
          stb.incBits = 1'b1;
          stb.shPost  = 1'b1;
          if (fieldCnt == LAST_POST) begin
            stb.endCheck = 1'b1;
            nextState    = ST_WAKE;
            nextCnt      = '0;
          end else nextCnt = fieldCnt + ONE;
        end
        ST_WAKE: begin
          if (fieldCnt == LAST_WAKE) begin nextState = ST_DONE; nextCnt = '0; end
          else nextCnt = fieldCnt + ONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_SEEK;
      fieldCnt <= '0;
      frameCnt <= '0;
    end else begin
      state    <= nextState;
      fieldCnt <= nextCnt;
      frameCnt <= nextFrm;
    end
  end

  assign done   = (state == ST_DONE);
  assign locked = state inside {ST_START, ST_DATA, ST_CHECK, ST_POST, ST_WAKE, ST_DONE};

endmodule

// File: rtl/cfgParseData.sv
module cfgParseData
  import cfgStreamPkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int LEN_BITS   = 24,
  parameter int CRC_BITS   = 4,
  parameter logic [CRC_BITS-1:0] CRC_POLY = 4'b0011,
  parameter int POST_BITS  = 4,
  parameter logic [POST_BITS-1:0] POSTAMBLE = 4'b0111,
  parameter int BYTE_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  byteMode,
  input  logic                  inValid,
  input  logic [BYTE_W-1:0]     dataIn,
  input  strobe_t               stb,
  output logic                  bitValid,
  output logic                  bitIn,
  output logic [FRAME_BITS-1:0] wordOut,
  output logic                  wordValid,
  output logic                  frameErr,
  output logic [LEN_BITS-1:0]   lengthOut,
  output logic                  endErr
);

  localparam int SH_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0]     byteSh;
  logic [SH_W-1:0]       bitsLeft;
  logic [LEN_BITS-1:0]   bitCount, lenReg;
  logic [FRAME_BITS-1:0] dataSh, dataNext;
  logic [CRC_BITS-1:0]   crc, crcNext, chk, chkNext;
  logic [POST_BITS-1:0]  postSh, postNext;
  logic                  badStart, crcFb;

  // byte replay: lowest data bit leaves first
  always_ff @(posedge clk) begin
    if (rst) begin
      byteSh   <= '0;
      bitsLeft <= '0;
    end else if (byteMode && inValid) begin
      byteSh   <= dataIn;
      bitsLeft <= SH_W'(BYTE_W);
    end else if (bitsLeft != '0) begin
      byteSh   <= {1'b0, byteSh[BYTE_W-1:1]};
      bitsLeft <= bitsLeft - SH_W'(1);
    end
  end

  assign bitValid = byteMode ? (bitsLeft != '0) : inValid;
  assign bitIn    = byteMode ? byteSh[0] : dataIn[0];

  assign dataNext = {dataSh[FRAME_BITS-2:0], bitIn};
  assign chkNext  = {chk[CRC_BITS-2:0], bitIn};
  assign postNext = {postSh[POST_BITS-2:0], bitIn};
  assign crcFb    = crc[CRC_BITS-1] ^ bitIn;
  assign crcNext  = {crc[CRC_BITS-2:0], 1'b0} ^ (crcFb ? CRC_POLY : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCount  <= '0;
      lenReg    <= '0;
      dataSh    <= '0;
      crc       <= '0;
      chk       <= '0;
      postSh    <= '0;
      badStart  <= 1'b0;
      wordOut   <= '0;
      wordValid <= 1'b0;
      frameErr  <= 1'b0;
      endErr    <= 1'b0;
    end else begin
      wordValid <= stb.emit;
      frameErr  <= stb.emit & (badStart | (~byteMode & (chkNext != crc)));
      if (stb.emit) wordOut <= byteMode ? dataNext : dataSh;
      if (stb.clrBits)      bitCount <= '0;
      else if (stb.incBits) bitCount <= bitCount + LEN_BITS'(1);
      if (stb.shLen) lenReg <= {lenReg[LEN_BITS-2:0], bitIn};
      if (stb.frameStart) begin
        badStart <= bitIn;
        crc      <= '0;
      end
      if (stb.shData) begin
        dataSh <= dataNext;
        crc    <= crcNext;
      end
      if (stb.shChk)  chk    <= chkNext;
      if (stb.shPost) postSh <= postNext;
      if (stb.endCheck && ((postNext != POSTAMBLE) || ((bitCount + LEN_BITS'(1)) != lenReg)))
        endErr <= 1'b1;
    end
  end

  assign lengthOut = lenReg;

endmodule

// File: rtl/cfgStreamParser.sv
module cfgStreamParser
  import cfgStreamPkg::*;
#(
  parameter int FRAME_BITS   = 8,
  parameter int NUM_FRAMES   = 3,
  parameter int LEN_BITS     = 24,
  parameter int SEP_BITS     = 4,
  parameter int FILL_BITS    = 24,
  parameter int CRC_BITS     = 4,
  parameter logic [CRC_BITS-1:0] CRC_POLY = 4'b0011,
  parameter int LEAD_ONES    = 8,
  parameter int PRE_BITS     = 4,
  parameter logic [PRE_BITS-1:0] PREAMBLE = 4'b0010,
  parameter int POST_BITS    = 4,
  parameter logic [POST_BITS-1:0] POSTAMBLE = 4'b0111,
  parameter int STARTUP_CLKS = 4,
  parameter int BYTE_W       = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  byteMode,
  input  logic                  inValid,
  input  logic [BYTE_W-1:0]     dataIn,
  output logic [FRAME_BITS-1:0] wordOut,
  output logic                  wordValid,
  output logic                  frameErr,
  output logic [LEN_BITS-1:0]   lengthOut,
  output logic                  endErr,
  output logic                  locked,
  output logic                  done
);

  strobe_t stb;
  logic    bitValid, bitIn;

  cfgParseCtrl #(
    .FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES), .LEN_BITS(LEN_BITS),
    .SEP_BITS(SEP_BITS), .FILL_BITS(FILL_BITS), .CRC_BITS(CRC_BITS),
    .LEAD_ONES(LEAD_ONES), .PRE_BITS(PRE_BITS), .PREAMBLE(PREAMBLE),
    .POST_BITS(POST_BITS), .STARTUP_CLKS(STARTUP_CLKS)
  ) ctrl_i (
    .clk(clk), .rst(rst), .byteMode(byteMode), .bitValid(bitValid), .bitIn(bitIn),
    .stb(stb), .locked(locked), .done(done)
  );

  cfgParseData #(
    .FRAME_BITS(FRAME_BITS), .LEN_BITS(LEN_BITS), .CRC_BITS(CRC_BITS),
    .CRC_POLY(CRC_POLY), .POST_BITS(POST_BITS), .POSTAMBLE(POSTAMBLE), .BYTE_W(BYTE_W)
  ) data_i (
    .clk(clk), .rst(rst), .byteMode(byteMode), .inValid(inValid), .dataIn(dataIn),
    .stb(stb), .bitValid(bitValid), .bitIn(bitIn), .wordOut(wordOut),
    .wordValid(wordValid), .frameErr(frameErr), .lengthOut(lengthOut), .endErr(endErr)
  );

endmodule

// File: rtl/cfgStreamParser_chk.sv
module cfgStreamParser_chk #(
  parameter int LEN_BITS = 24
) (
  input logic                clk,
  input logic                rst,
  input logic                byteMode,
  input logic                wordValid,
  input logic                frameErr,
  input logic [LEN_BITS-1:0] lengthOut,
  input logic                endErr,
  input logic                locked,
  input logic                done
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!done && !locked && !wordValid && !endErr && !frameErr && lengthOut == '0));

  p_len_hold_r3: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(lengthOut));

  p_word_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  p_err_with_word_r5: assert property (@(posedge clk) disable iff (rst)
    frameErr |-> wordValid);

  p_end_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    endErr |=> endErr);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !wordValid);

  p_byte_no_len_r8: assert property (@(posedge clk) disable iff (rst)
    byteMode |-> (lengthOut == '0 && !endErr));

  p_locked_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

endmodule

bind cfgStreamParser cfgStreamParser_chk #(.LEN_BITS(LEN_BITS)) chk_i (
  .clk(clk), .rst(rst), .byteMode(byteMode), .wordValid(wordValid),
  .frameErr(frameErr), .lengthOut(lengthOut), .endErr(endErr),
  .locked(locked), .done(done)
);

// File: tb/cfgStreamParser_tb_top.sv
module cfgStreamParser_tb_top;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] w;
    logic       e;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byteMode = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  wordOut;
  logic        wordValid, frameErr, endErr, locked, done;
  logic [23:0] lengthOut;

  exp_t expQ[$];
  logic bitsQ[$];
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgStreamParser dut_i (
    .clk(clk), .rst(rst), .byteMode(byteMode), .inValid(inValid), .dataIn(dataIn),
    .wordOut(wordOut), .wordValid(wordValid), .frameErr(frameErr),
    .lengthOut(lengthOut), .endErr(endErr), .locked(locked), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a word appears
  always @(negedge clk) begin
    if (!rst && wordValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected word actual %0h/%0b expected none", wordOut, frameErr);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (wordOut !== e.w || frameErr !== e.e) begin
          errors++;
          $display("FAIL R4/R5 word actual %0h/%0b expected %0h/%0b", wordOut, frameErr, e.w, e.e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R7 watchdog actual %0d expected below 20000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [3:0] crcOf(input logic [7:0] w);
    logic [3:0] c = '0;
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[3] ^ w[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    end
    return c;
  endfunction

  task automatic pushField(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitsQ.push_back(v[i]);
  endtask

  task automatic addFrame(input logic [7:0] w, input logic badStart, input logic badCrc,
                          input logic byteM);
    exp_t e;
    pushField({31'd0, badStart}, 1);
    pushField({24'd0, w}, 8);
    if (!byteM) pushField({28'd0, crcOf(w) ^ (badCrc ? 4'b0101 : 4'b0000)}, 4);
    e.w = w;
    e.e = badStart | badCrc;
    expQ.push_back(e);
  endtask

  task automatic doReset(input logic m);
    @(negedge clk);
    rst = 1'b1;
    byteMode = m;
    inValid = 1'b0;
    expQ.delete();
    bitsQ.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // serial: one bit per cycle, an ignored idle cycle after every seventh bit
  task automatic sendSerial();
    int n = 0;
    foreach (bitsQ[i]) begin
      @(negedge clk);
      inValid = 1'b1;
      dataIn  = {7'b1010101, bitsQ[i]};
      @(posedge clk);
      #1;
      inValid = 1'b0;
      n++;
      if (n % 7 == 0) begin
        @(negedge clk);
        dataIn = ~dataIn;
        @(posedge clk);
        #1;
      end
    end
    bitsQ.delete();
  endtask

  task automatic sendBytes();
    while (bitsQ.size() % 8 != 0) bitsQ.push_back(1'b1);
    for (int k = 0; k < bitsQ.size() / 8; k++) begin
      logic [7:0] b;
      for (int j = 0; j < 8; j++) b[j] = bitsQ[8*k + j];
      @(negedge clk);
      inValid = 1'b1;
      dataIn  = b;
      @(negedge clk);
      inValid = 1'b0;
      repeat (6) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    bitsQ.delete();
  endtask

  task automatic serialHeader(input logic [23:0] len);
    pushField(32'hFF, 8);
    pushField(32'b0010, 4);
    pushField({8'd0, len}, 24);
    pushField(32'hF, 4);
  endtask

  initial begin
    // R1: reset state
    doReset(1'b0);
    @(negedge clk);
    check("R1 done", {31'd0, done}, 0);
    check("R1 locked", {31'd0, locked}, 0);
    check("R1 endErr", {31'd0, endErr}, 0);
    check("R1 lengthOut", {8'd0, lengthOut}, 0);

    // R2: noise then a failed preamble, no lock
    pushField(32'b01110, 5);
    pushField(32'hFF, 8);
    pushField(32'b10, 2);
    sendSerial();
    check("R2 locked after noise", {31'd0, locked}, 0);

    // good serial stream: 8+4+24+4+3*13+4 = 83 bits
    serialHeader(24'd83);
    addFrame(8'hA5, 1'b0, 1'b0, 1'b0);
    addFrame(8'h3C, 1'b0, 1'b0, 1'b0);
    addFrame(8'hFF, 1'b0, 1'b0, 1'b0);
    pushField(32'b0111, 4);
    pushField(32'b010, 3);
    sendSerial();
    check("R9 locked", {31'd0, locked}, 1);
    check("R3 lengthOut", {8'd0, lengthOut}, 83);
    check("R6 endErr good stream", {31'd0, endErr}, 0);
    check("R4 all words seen", expQ.size(), 0);
    check("R7 done before fourth start-up bit", {31'd0, done}, 0);
    pushField(32'b0, 1);
    sendSerial();
    check("R7 done after fourth start-up bit", {31'd0, done}, 1);
    // R7: later input ignored
    serialHeader(24'd5);
    addFrame(8'h11, 1'b0, 1'b0, 1'b0);
    expQ.delete();
    sendSerial();
    check("R7 done held", {31'd0, done}, 1);
    check("R7 lengthOut unchanged", {8'd0, lengthOut}, 83);

    // R5/R6: bad CRC, bad start bit, wrong length
    doReset(1'b0);
    serialHeader(24'd84);
    addFrame(8'h12, 1'b0, 1'b1, 1'b0);
    addFrame(8'h80, 1'b0, 1'b0, 1'b0);
    addFrame(8'h01, 1'b1, 1'b0, 1'b0);
    pushField(32'b0111, 4);
    pushField(32'hF, 4);
    sendSerial();
    check("R6 endErr on length mismatch", {31'd0, endErr}, 1);
    check("R5 all words seen", expQ.size(), 0);
    check("R7 done", {31'd0, done}, 1);

    // R6: bad postamble with correct length
    doReset(1'b0);
    serialHeader(24'd83);
    addFrame(8'h5A, 1'b0, 1'b0, 1'b0);
    addFrame(8'h00, 1'b0, 1'b0, 1'b0);
    addFrame(8'hC7, 1'b0, 1'b0, 1'b0);
    pushField(32'b0110, 4);
    pushField(32'h0, 4);
    sendSerial();
    check("R6 endErr on bad postamble", {31'd0, endErr}, 1);
    check("R6 lengthOut", {8'd0, lengthOut}, 83);

    // R8: byte-wide mode
    doReset(1'b1);
    pushField(32'hFF, 8);
    pushField(32'b0010, 4);
    pushField(32'h5A0F3C, 24);
    addFrame(8'hC3, 1'b0, 1'b0, 1'b1);
    addFrame(8'h5A, 1'b1, 1'b0, 1'b1);
    addFrame(8'h0F, 1'b0, 1'b0, 1'b1);
    pushField(32'h0, 4);
    sendBytes();
    check("R8 done", {31'd0, done}, 1);
    check("R8 lengthOut zero", {8'd0, lengthOut}, 0);
    check("R8 endErr low", {31'd0, endErr}, 0);
    check("R8 all words seen", expQ.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule